// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables that live in memory. The upper ten address bits pick an entry in a top-level directory, and that entry gives the base of a second-level table. The next ten bits pick an entry in that table, which supplies the physical frame. The low twelve bits are the offset inside a 4096-byte page and pass straight through.

The directory base sits in a root register. Only a write marked as privileged can load it. A write without privilege leaves the register unchanged and produces a one-cycle error pulse. A requester hands over one address at a time while the walker is idle. The walker then issues the directory read, waits for its data, issues the table read and waits again. It answers with a single response pulse that carries either the physical address or a fault flag. Memory reads use a one-cycle strobe and a data-valid return with any latency.

Top module: `pt_walker`

## Requirements
- R1: On a successful translation, physical address bits [11:0] equal virtual address bits [11:0].
- R2: The first memory read of a walk is at root_base + va[31:22]*4. root_base is the root register with its low 12 bits forced to zero.
- R3: When the directory entry has bit 0 set, the second read is at {pde[31:12], 12'h000} + va[21:12]*4.
- R4: When the table entry has bit 0 set, the response has rsp_fault=0 and rsp_paddr={pte[31:12], va[11:0]}. Each read strobe lasts one cycle, and the table read is never issued before the directory data has returned.
- R5: A directory entry with bit 0 clear ends the walk after one read. The response then has rsp_fault=1 and rsp_paddr=0.
- R6: A table entry with bit 0 clear gives a response with rsp_fault=1 and rsp_paddr=0, after exactly two reads.
- R7: A write with root_wr_en=1 and root_wr_priv=1 loads root_wr_data[31:12] into the root register, and the next walk uses it. Bits [11:0] of the write data are ignored.
- R8: A write with root_wr_en=1 and root_wr_priv=0 leaves the root register unchanged. It raises root_err for exactly the one cycle after the write.
- R9: A request is taken only while req_ready=1, which happens only when the walker is idle. busy stays high from the cycle after acceptance through the response cycle. rsp_valid is high for one cycle per accepted request. req_valid is ignored while busy.
- R10: For virtual address 0xCAFEBABE, the directory index is 0x32B, the table index is 0x3EB and the offset is 0xABE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_wr_en | input | 1 | Root register write strobe |
| root_wr_priv | input | 1 | Write carries privilege |
| root_wr_data | input | 32 | New directory base (bits [31:12] used) |
| root_err | output | 1 | One-cycle pulse on a refused write |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request will be taken |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Translated physical address, zero on fault |
| mem_rd_en | output | 1 | One-cycle memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Returned table entry |

## Verification
The assertions assume memory returns exactly one mem_rd_valid pulse for each read strobe, and only after that strobe. Unsolicited data would be taken as an entry. The bench memory model meets this by holding one pending read at a time and answering it after a random latency of zero to three cycles. Root register writes are issued only while the walker is idle. Entry contents come from a hashed-address function with a few fixed overrides for the directed corner cases.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int DIR_W    = 10,
  parameter int TBL_W    = 10,
  parameter int ENTRY_SH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_wr_en,
  input  logic              root_wr_priv,
  input  logic [ADDR_W-1:0] root_wr_data,
  output logic              root_err,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data
);
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int DIR_LO  = OFF_W + TBL_W;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_WT, S_TBL_RD, S_TBL_WT, S_RESP
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] pa_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] tbase_q;
  logic              fault_q;
  logic              root_err_q;

  logic [DIR_W-1:0]  dir_idx;
  logic [TBL_W-1:0]  tbl_idx;
  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;

  assign dir_idx  = va_q[DIR_LO +: DIR_W];
  assign tbl_idx  = va_q[OFF_W +: TBL_W];
  assign dir_addr = {root_q, {OFF_W{1'b0}}} + (ADDR_W'(dir_idx) << ENTRY_SH);
  assign tbl_addr = {tbase_q, {OFF_W{1'b0}}} + (ADDR_W'(tbl_idx) << ENTRY_SH);

  assign req_ready   = (st == S_IDLE);
  assign busy        = (st != S_IDLE);
  assign rsp_valid   = (st == S_RESP);
  assign rsp_fault   = rsp_valid && fault_q;
  assign rsp_paddr   = rsp_valid ? pa_q : '0;
  assign mem_rd_en   = (st == S_DIR_RD) || (st == S_TBL_RD);
  assign mem_rd_addr = (st == S_TBL_RD) ? tbl_addr : dir_addr;
  assign root_err    = root_err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      pa_q       <= '0;
      root_q     <= '0;
      tbase_q    <= '0;
      fault_q    <= 1'b0;
      root_err_q <= 1'b0;
    end else begin
      root_err_q <= root_wr_en && !root_wr_priv;
      if (root_wr_en && root_wr_priv)
        root_q <= root_wr_data[ADDR_W-1:OFF_W];
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          fault_q <= 1'b0;
          st      <= S_DIR_RD;
        end
        S_DIR_RD: st <= S_DIR_WT;
        S_DIR_WT: if (mem_rd_valid) begin
          if (!mem_rd_data[0]) begin
            fault_q <= 1'b1;
            pa_q    <= '0;
            st      <= S_RESP;
          end else begin
            tbase_q <= mem_rd_data[ADDR_W-1:OFF_W];
            st      <= S_TBL_RD;
          end
        end
        S_TBL_RD: st <= S_TBL_WT;
        S_TBL_WT: if (mem_rd_valid) begin
          fault_q <= !mem_rd_data[0];
          pa_q    <= mem_rd_data[0] ? {mem_rd_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
          st      <= S_RESP;
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     root_wr_en,
  input logic                     root_wr_priv,
  input logic [ADDR_W-1:0]        root_wr_data,
  input logic                     root_err,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     busy,
  input logic                     rsp_valid,
  input logic                     rsp_fault,
  input logic [ADDR_W-1:0]        rsp_paddr,
  input logic                     mem_rd_en,
  input logic [ADDR_W-OFF_W-1:0]  root_q,
  input logic [ADDR_W-1:0]        va_q
);
  logic [ADDR_W-OFF_W-1:0] wr_frame;
  assign wr_frame = root_wr_data[ADDR_W-1:OFF_W];

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));
  a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0));
  a_r7_root_load: assert property (@(posedge clk) disable iff (!rst_n)
    (root_wr_en && root_wr_priv) |=> (root_q == $past(wr_frame)));
  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (root_wr_en && !root_wr_priv) |=> root_err);
  a_r8_root_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (root_wr_en && !root_wr_priv) |=> (root_q == $past(root_q)));
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .root_wr_en(root_wr_en), .root_wr_priv(root_wr_priv),
  .root_wr_data(root_wr_data), .root_err(root_err), .req_valid(req_valid),
  .req_ready(req_ready), .busy(busy), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .mem_rd_en(mem_rd_en), .root_q(root_q), .va_q(va_q)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_wr_en = 1'b0, root_wr_priv = 1'b0;
  logic [31:0] root_wr_data = '0;
  logic        root_err;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, busy, rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  int n_tests = 0, n_fail = 0;
  logic [31:0] root_model = '0;
  logic [31:0] ov_a [8];
  logic [31:0] ov_d [8];
  int          ov_n = 0;

  always #4 clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_wr_en(root_wr_en), .root_wr_priv(root_wr_priv),
    .root_wr_data(root_wr_data), .root_err(root_err), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_ready(req_ready), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    for (int i = 0; i < 8; i++)
      if (i < ov_n && ov_a[i] == a) return ov_d[i];
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    return {h[31:12], 11'b0, (h[6:4] != 3'd0)};
  endfunction

  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pend_a = '0;
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en) begin
      pend   <= 1'b1;
      cnt    <= int'($urandom_range(3, 0));
      pend_a <= mem_rd_addr;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem_word(pend_a);
        pend         <= 1'b0;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_root(input logic [31:0] d, input bit priv);
    @(negedge clk);
    root_wr_en = 1'b1; root_wr_priv = priv; root_wr_data = d;
    @(negedge clk);
    root_wr_en = 1'b0; root_wr_priv = 1'b0;
    if (priv) begin
      root_model = {d[31:12], 12'h000};
      chk(root_err == 1'b0, "R7", "root_err after privileged write", 32'(root_err), 32'd0);
    end else begin
      chk(root_err == 1'b1, "R8", "root_err pulse", 32'(root_err), 32'd1);
      @(negedge clk);
      chk(root_err == 1'b0, "R8", "root_err one cycle", 32'(root_err), 32'd0);
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit noise, input string tag,
                      output logic [31:0] a0, output logic [31:0] a1,
                      output logic [31:0] pa);
    logic [31:0] pde, pte, e0, e1, epa;
    bit ef, got_rsp;
    int nrd, enr, cyc;
    logic f;
    e0 = root_model + {20'b0, va[31:22], 2'b00};
    pde = mem_word(e0);
    e1 = {pde[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
    enr = pde[0] ? 2 : 1;
    pte = mem_word(e1);
    ef = !pde[0] || !pte[0];
    epa = ef ? 32'h0 : {pte[31:12], va[11:0]};

    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    nrd = 0; got_rsp = 0; a0 = '0; a1 = '0; pa = '0; f = 1'b0;
    for (cyc = 0; cyc < 64 && !got_rsp; cyc++) begin
      if (!busy) chk(1'b0, "R9", "busy during walk", 32'(busy), 32'd1);
      if (noise) begin req_valid = 1'b1; req_vaddr = ~va; end
      if (mem_rd_en) begin
        if (nrd == 0) a0 = mem_rd_addr; else a1 = mem_rd_addr;
        nrd++;
      end
      if (rsp_valid) begin got_rsp = 1; pa = rsp_paddr; f = rsp_fault; end
      else @(negedge clk);
    end
    req_valid = 1'b0;
    chk(got_rsp, "R9", {tag, " response seen"}, 32'(got_rsp), 32'd1);
    chk(nrd == enr, pde[0] ? "R6" : "R5", {tag, " read count"}, 32'(nrd), 32'(enr));
    chk(a0 == e0, "R2", {tag, " directory read address"}, a0, e0);
    if (pde[0]) chk(a1 == e1, "R3", {tag, " table read address"}, a1, e1);
    chk(f == ef, ef ? "R5" : "R4", {tag, " fault flag"}, 32'(f), 32'(ef));
    chk(pa == epa, "R4", {tag, " physical address"}, pa, epa);
    if (!ef) chk(pa[11:0] == va[11:0], "R1", {tag, " offset"}, pa, va);
    @(negedge clk);
    chk(!rsp_valid && !busy, "R9", {tag, " single response pulse"}, 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a0, a1, pa;
    void'($urandom(32'd20240611));
    ov_a[0] = 32'h00100CAC; ov_d[0] = 32'h00234001;
    ov_a[1] = 32'h00234FAC; ov_d[1] = 32'h0ABCD001;
    ov_a[2] = 32'h00100004; ov_d[2] = 32'h00000000;
    ov_a[3] = 32'h00100008; ov_d[3] = 32'h00300001;
    ov_a[4] = 32'h00300000; ov_d[4] = 32'hFFFFF000;
    ov_n = 5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready && !rsp_valid && !mem_rd_en && !root_err,
        "R9", "reset state idle", {27'b0, busy, req_ready, rsp_valid, mem_rd_en, root_err}, 32'h8);

    wr_root(32'h00100000, 1'b1);
    walk(32'hCAFEBABE, 1'b0, "cafebabe", a0, a1, pa);
    chk(a0[11:2] == 10'h32B, "R10", "directory index", 32'(a0[11:2]), 32'h32B);
    chk(a1[11:2] == 10'h3EB, "R10", "table index", 32'(a1[11:2]), 32'h3EB);
    chk(pa == 32'h0ABCDABE, "R10", "offset and frame", pa, 32'h0ABCDABE);

    walk(32'h00400000, 1'b0, "dir absent", a0, a1, pa);
    chk(pa == 32'h0, "R5", "fault address zero", pa, 32'h0);
    walk(32'h00800123, 1'b0, "tbl absent", a0, a1, pa);
    chk(a1 == 32'h00300000, "R6", "second read issued", a1, 32'h00300000);

    wr_root(32'h00100FFF, 1'b1);
    walk(32'hCAFEBABE, 1'b0, "root low bits", a0, a1, pa);
    chk(a0 == 32'h00100CAC, "R7", "low write bits ignored", a0, 32'h00100CAC);

    wr_root(32'h00700000, 1'b0);
    walk(32'hCAFEBABE, 1'b0, "refused write", a0, a1, pa);
    chk(a0 == 32'h00100CAC, "R8", "root unchanged", a0, 32'h00100CAC);

    walk(32'hCAFEBABE, 1'b1, "busy noise", a0, a1, pa);
    chk(pa == 32'h0ABCDABE, "R9", "request during walk ignored", pa, 32'h0ABCDABE);
    @(negedge clk);
    chk(!busy, "R9", "no second walk from noise", 32'(busy), 32'd0);

    for (int i = 0; i < 150; i++) begin
      if (($urandom & 32'h7) == 0)
        wr_root($urandom, ($urandom & 32'h3) != 0);
      walk($urandom, (($urandom & 32'h3) == 0), "random", a0, a1, pa);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule